// File: doc/BRIEF.md
# Parallel-Select Arithmetic/Logic Unit

This block is the arithmetic and logic core of a small register machine's execute stage. It has no clock and no state. Two operand words, A and B, and a 3-bit function code go in, and one result word comes out. Every candidate result is formed at the same time by separate sub-units: an add/subtract unit, a bitwise unit and a shifter. A final select network then picks the one named by the function code. One function copies operand B straight to the result. The machine uses it to route an immediate address into the register file. Branch condition tests are made elsewhere, so the unit produces no flags, carry or overflow indication.

The word width is a parameter, 16 by default. Two parameters pick how sub-units are built. `SHARED_ADDER` chooses between one adder that inverts B for subtraction and two separate adders. `BARREL_SHIFT` chooses between a staged logarithmic shifter and a plain shift operator. The results are the same in every variant.

Top module: `alu16`

## Requirements
- R1: Function code 3'b000 outputs (A + B) mod 2^W with the carry discarded; for W=16, A=0x0028 and B=0x0064 give 0x008C.
- R2: Function code 3'b001 outputs (A - B) mod 2^W in two's complement.
- R3: Function code 3'b010 outputs the bitwise AND of A and B.
- R4: Function code 3'b011 outputs the bitwise XOR of A and B.
- R5: Function code 3'b100 outputs A shifted left by the whole unsigned value of B, with zeros filling the vacated low bits.
- R6: Function code 3'b101 outputs A shifted right logically by the whole unsigned value of B, with zeros filling the vacated high bits.
- R7: For both shift codes, a B value of W or more gives an all-zero result.
- R8: Function code 3'b110 outputs B unchanged, whatever A holds.
- R9: Function code 3'b111 outputs all zeros, whatever A and B hold.
- R10: The result is purely combinational: it follows a change of A, B or the function code within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand (A) |
| opb_i | input | WIDTH | Second operand (B); also the shift amount and the pass-through value |
| func_i | input | 3 | Function code |
| res_o | output | WIDTH | Selected result |

## Verification
The bench builds two copies of the unit.

- The first uses the default 16-bit width, with a shared adder and the staged shifter. It runs structured operand patterns: walking ones, all-ones, sign-boundary values and the 0x0028/0x0064 example. Shift amounts run from 0 up past 16, so wrap-around and every stage of the shifter are reached.
- The second is a 5-bit copy with separate adders and the operator shifter. At that width all 32×32 operand pairs under all eight function codes are swept exhaustively. That covers every carry chain, every shift amount including the over-range values 5 to 31, and the unused code, in the other construction variants.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   localparam int FUNC_BITS = 3;

   typedef enum logic [FUNC_BITS-1:0] {
      FN_ADD  = 3'b000,
      FN_SUB  = 3'b001,
      FN_AND  = 3'b010,
      FN_XOR  = 3'b011,
      FN_SHL  = 3'b100,
      FN_SHR  = 3'b101,
      FN_PASS = 3'b110,
      FN_NONE = 3'b111
   } alu_func_e;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
   parameter int WIDTH        = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu16_addsub: WIDTH must be at least 2");
   end

   if (SHARED_ADDER) begin : g_shared
      // one carry chain; subtraction via inverted B plus carry-in
      logic [WIDTH-1:0] b_eff;
      logic [WIDTH-1:0] cin_vec;
      always_comb begin
         b_eff   = sub_i ? ~b_i : b_i;
         cin_vec = '0;
         cin_vec[0] = sub_i;
         sum_o   = a_i + b_eff + cin_vec;
      end
   end else begin : g_split
      // two independent chains, selected afterwards
      logic [WIDTH-1:0] plus_r;
      logic [WIDTH-1:0] minus_r;
      always_comb begin
         plus_r  = a_i + b_i;
         minus_r = a_i - b_i;
         sum_o   = sub_i ? minus_r : plus_r;
      end
   end

endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] xor_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_o[i] = a_i[i] & b_i[i];
      assign xor_o[i] = a_i[i] ^ b_i[i];
   end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
   parameter int WIDTH        = 16,
   parameter bit BARREL_SHIFT = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] amt_i,
   output logic [WIDTH-1:0] shl_o,
   output logic [WIDTH-1:0] shr_o
);

   localparam int SH_BITS = $clog2(WIDTH);
   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(WIDTH);

   if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
      $error("alu16_shift: WIDTH must lie in 2..32");
   end

   // amounts of WIDTH or more empty the word in both directions
   logic over_range;
   assign over_range = (amt_i >= LIMIT);

   logic [SH_BITS-1:0] amt_lo;
   assign amt_lo = amt_i[SH_BITS-1:0];

   if (BARREL_SHIFT) begin : g_barrel
      logic [WIDTH-1:0] lstg [0:SH_BITS];
      logic [WIDTH-1:0] rstg [0:SH_BITS];
      assign lstg[0] = a_i;
      assign rstg[0] = a_i;
      for (genvar k = 0; k < SH_BITS; k++) begin : g_stage
         assign lstg[k+1] = amt_lo[k] ? (lstg[k] << (1 << k)) : lstg[k];
         assign rstg[k+1] = amt_lo[k] ? (rstg[k] >> (1 << k)) : rstg[k];
      end
      assign shl_o = over_range ? '0 : lstg[SH_BITS];
      assign shr_o = over_range ? '0 : rstg[SH_BITS];
   end else begin : g_operator
      assign shl_o = over_range ? '0 : (a_i << amt_lo);
      assign shr_o = over_range ? '0 : (a_i >> amt_lo);
   end

endmodule

// File: rtl/alu16.sv
module alu16
   import alu16_pkg::*;
#(
   parameter int WIDTH        = 16,
   parameter bit SHARED_ADDER = 1'b1,
   parameter bit BARREL_SHIFT = 1'b1
) (
   input  logic [WIDTH-1:0]     opa_i,
   input  logic [WIDTH-1:0]     opb_i,
   input  logic [FUNC_BITS-1:0] func_i,
   output logic [WIDTH-1:0]     res_o
);

   if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
      $error("alu16: WIDTH must lie in 2..32");
   end

   logic [WIDTH-1:0] arith_r;
   logic [WIDTH-1:0] and_r;
   logic [WIDTH-1:0] xor_r;
   logic [WIDTH-1:0] shl_r;
   logic [WIDTH-1:0] shr_r;
   logic             is_sub;

   assign is_sub = (func_i == FN_SUB);

   alu16_addsub #(
      .WIDTH        (WIDTH),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_addsub (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .sub_i (is_sub),
      .sum_o (arith_r)
   );

   alu16_bitwise #(
      .WIDTH (WIDTH)
   ) u_bitwise (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .and_o (and_r),
      .xor_o (xor_r)
   );

   alu16_shift #(
      .WIDTH        (WIDTH),
      .BARREL_SHIFT (BARREL_SHIFT)
   ) u_shift (
      .a_i   (opa_i),
      .amt_i (opb_i),
      .shl_o (shl_r),
      .shr_o (shr_r)
   );

   // final result select
   always_comb begin
      unique case (alu_func_e'(func_i))
         FN_ADD,
         FN_SUB:  res_o = arith_r;
         FN_AND:  res_o = and_r;
         FN_XOR:  res_o = xor_r;
         FN_SHL:  res_o = shl_r;
         FN_SHR:  res_o = shr_r;
         FN_PASS: res_o = opb_i;
         default: res_o = '0;
      endcase
   end

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk
   import alu16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0]     opa_i,
   input logic [WIDTH-1:0]     opb_i,
   input logic [FUNC_BITS-1:0] func_i,
   input logic [WIDTH-1:0]     res_o
);

   localparam logic [WIDTH-1:0] LIMIT = WIDTH'(WIDTH);
   localparam logic [WIDTH-1:0] ONES  = '1;

   logic [WIDTH-1:0] back_add;
   logic [WIDTH-1:0] back_sub;
   logic [WIDTH-1:0] back_xor;

   always_comb begin
      back_add = res_o - opb_i;
      back_sub = res_o + opb_i;
      back_xor = res_o ^ opb_i;

      if (func_i == FN_ADD)
         a_r1_add_inverse: assert (back_add == opa_i)
            else $error("R1 add result inconsistent");
      if (func_i == FN_SUB)
         a_r2_sub_inverse: assert (back_sub == opa_i)
            else $error("R2 sub result inconsistent");
      if (func_i == FN_AND)
         a_r3_and_subset: assert (((res_o & ~opa_i) == '0) && ((res_o & ~opb_i) == '0))
            else $error("R3 and result sets bits absent in an operand");
      if (func_i == FN_XOR)
         a_r4_xor_inverse: assert (back_xor == opa_i)
            else $error("R4 xor result inconsistent");
      if (func_i == FN_SHL && opb_i < LIMIT)
         a_r5_shl_zero_fill: assert ((res_o & ~(ONES << opb_i)) == '0)
            else $error("R5 shl low bits not zero");
      if (func_i == FN_SHR && opb_i < LIMIT)
         a_r6_shr_zero_fill: assert ((res_o & ~(ONES >> opb_i)) == '0)
            else $error("R6 shr high bits not zero");
      if ((func_i == FN_SHL || func_i == FN_SHR) && opb_i >= LIMIT)
         a_r7_shift_over: assert (res_o == '0)
            else $error("R7 over-range shift not zero");
      if (func_i == FN_PASS)
         a_r8_pass_b: assert (res_o == opb_i)
            else $error("R8 pass result differs from B");
      if (func_i == FN_NONE)
         a_r9_unused_zero: assert (res_o == '0)
            else $error("R9 unused code not zero");
   end

endmodule

bind alu16 alu16_chk #(
   .WIDTH (WIDTH)
) u_alu16_chk (
   .opa_i  (opa_i),
   .opb_i  (opb_i),
   .func_i (func_i),
   .res_o  (res_o)
);

// File: tb/tb_alu16.sv
module tb_alu16;

   localparam int W_BIG   = 16;
   localparam int W_SMALL = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   logic [W_BIG-1:0]   a16, b16, y16;
   logic [2:0]         f16;
   logic [W_SMALL-1:0] a5, b5, y5;
   logic [2:0]         f5;

   alu16 #(.WIDTH(W_BIG), .SHARED_ADDER(1'b1), .BARREL_SHIFT(1'b1)) dut (
      .opa_i(a16), .opb_i(b16), .func_i(f16), .res_o(y16));

   alu16 #(.WIDTH(W_SMALL), .SHARED_ADDER(1'b0), .BARREL_SHIFT(1'b0)) dut_small (
      .opa_i(a5), .opb_i(b5), .func_i(f5), .res_o(y5));

   // reference model computed from the requirements
   function automatic longint model(int w, int fn, longint a, longint b);
      longint m = (longint'(1) << w);
      case (fn)
         0: return (a + b) % m;
         1: return (a - b + m) % m;
         2: return a & b;
         3: return a ^ b;
         4: return (b >= w) ? 0 : ((a << b) % m);
         5: return (b >= w) ? 0 : (a >> b);
         6: return b;
         default: return 0;
      endcase
   endfunction

   function automatic string tag(int fn, longint b, int w);
      if ((fn == 4 || fn == 5) && b >= w) return "R7";
      case (fn)
         0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
         4: return "R5"; 5: return "R6"; 6: return "R8"; default: return "R9";
      endcase
   endfunction

   task automatic cmp(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run16(int fn, logic [W_BIG-1:0] a, logic [W_BIG-1:0] b);
      @(negedge clk);
      f16 = fn[2:0]; a16 = a; b16 = b;
      #1;
      cmp(tag(fn, longint'(b), W_BIG), longint'(y16), model(W_BIG, fn, longint'(a), longint'(b)));
   endtask

   task automatic run5(int fn, int a, int b);
      @(negedge clk);
      f5 = fn[2:0]; a5 = a[W_SMALL-1:0]; b5 = b[W_SMALL-1:0];
      #1;
      cmp(tag(fn, longint'(b), W_SMALL), longint'(y5), model(W_SMALL, fn, longint'(a), longint'(b)));
   endtask

   logic [W_BIG-1:0] pats [0:11];

   initial begin
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h0001; pats[3] = 16'h8000;
      pats[4] = 16'h7FFF; pats[5] = 16'h0028; pats[6] = 16'h0064; pats[7] = 16'hA5A5;
      pats[8] = 16'h5A5A; pats[9] = 16'h00FF; pats[10] = 16'hFF00; pats[11] = 16'h1234;
      a16 = '0; b16 = '0; f16 = '0; a5 = '0; b5 = '0; f5 = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // idle state: zero operands under add give zero (R1)
      @(negedge clk);
      cmp("R1", longint'(y16), 0);

      // worked example (R1)
      run16(0, 16'h0028, 16'h0064);
      cmp("R1", longint'(y16), 64'h008C);

      // structured 16-bit sweep: all codes, patterns, shift amounts 0..20 (R1..R9)
      for (int fn = 0; fn < 8; fn++)
         for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) run16(fn, pats[i], pats[j]);
            for (int s = 0; s <= 20; s++) run16(fn, pats[i], W_BIG'(s));
         end
      // walking one through both shifters (R5, R6)
      for (int p = 0; p < W_BIG; p++)
         for (int s = 0; s < W_BIG; s++) begin
            run16(4, W_BIG'(1) << p, W_BIG'(s));
            run16(5, W_BIG'(1) << p, W_BIG'(s));
         end

      // R10: two input changes inside one clock period, each seen without an edge
      @(negedge clk);
      f16 = 3'b011; a16 = 16'h0F0F; b16 = 16'h00FF;
      #1 cmp("R10", longint'(y16), 64'h0FF0);
      f16 = 3'b110; b16 = 16'hBEEF;
      #1 cmp("R10", longint'(y16), 64'hBEEF);
      f16 = 3'b001; a16 = 16'h0000; b16 = 16'h0001;
      #1 cmp("R10", longint'(y16), 64'hFFFF);

      // exhaustive 5-bit sweep (R1..R9)
      for (int fn = 0; fn < 8; fn++)
         for (int a = 0; a < 32; a++)
            for (int b = 0; b < 32; b++)
               run5(fn, a, b);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule